// File: doc/BRIEF.md
# Prefix Compound Adder

This is a combinational adder that delivers two results for one pair of unsigned `WIDTH`-bit operands at once: the plain sum a+b and the incremented sum a+b+1. Each result comes with its own carry-out bit. A floating-point datapath places it after operand alignment. Rounding then becomes a choice between two sums that are already computed, and no incrementer follows the adder.

Each bit position is reduced to a three-valued carry status: kill, propagate or generate. One logarithmic-depth prefix network combines these statuses with an associative merge operator, so every position holds the status of the span from itself down to bit 0. A final per-position merge with a seed turns that one shared set of group statuses into two carry vectors. The seed is kill for the plain sum and generate for the incremented sum.

A select input picks which of the two sums, with its carry-out, appears on the result outputs. The block does not make the rounding decision itself.

Top module: `compound_adder`

## Requirements
- R1: `{sum_co_o, sum_o}` equals a+b computed as a `WIDTH`+1-bit unsigned sum.
- R2: `{inc_co_o, inc_o}` equals a+b+1 computed as a `WIDTH`+1-bit unsigned sum.
- R3: When `rnd_up_i` is 0, `{res_co_o, res_o}` equals `{sum_co_o, sum_o}`.
- R4: When `rnd_up_i` is 1, `{res_co_o, res_o}` equals `{inc_co_o, inc_o}`.
- R5: With both operands all ones (generate at every bit), the plain sum is all ones except bit 0 with carry-out 1, and the incremented sum is all ones with carry-out 1.
- R6: When a XOR b is all ones (propagate at every bit), the plain sum is all ones with carry-out 0, and the incremented sum is zero with carry-out 1.
- R7: With both operands zero (kill at every bit), the plain sum is 0 with carry-out 0, and the incremented sum is 1 with carry-out 0.
- R8: Bit status is kill (code 00) when both operand bits are 0, generate (code 10) when both are 1, and propagate (code 01) otherwise. The carry into bit i+1 is 1 when the merged status of bits i..0 is generate, for the plain sum, or is not kill, for the incremented sum. For example, with `WIDTH`=6, 000100 + 001110 gives 010010, and the incremented sum is 010011.
- R9: The results are correct for any `WIDTH`, including 6 and the default of 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | first operand |
| b_i | input | WIDTH | second operand |
| rnd_up_i | input | 1 | 1 selects the incremented sum for the result |
| sum_o | output | WIDTH | a+b, low WIDTH bits |
| sum_co_o | output | 1 | carry-out of a+b |
| inc_o | output | WIDTH | a+b+1, low WIDTH bits |
| inc_co_o | output | 1 | carry-out of a+b+1 |
| res_o | output | WIDTH | selected sum |
| res_co_o | output | 1 | carry-out of the selected sum |

## Verification
The checks in the checker module are immediate and evaluated as the logic settles. They assume the operand and select inputs hold fully known 0/1 values and change only as a group. The bench changes all inputs together on the rising clock edge and reads the outputs on the falling edge, when the network has settled. The operand values themselves need no constraint: the checks hold for every pair, and stimulus covers every 6-bit pair plus directed and random 24-bit pairs, including the all-ones operand.

// File: rtl/cadd_pkg.sv
package cadd_pkg;

  // carry status of a bit span
  typedef enum logic [1:0] {
    KPG_KILL = 2'b00,
    KPG_PROP = 2'b01,
    KPG_GEN  = 2'b10
  } kpg_e;

  function automatic kpg_e kpg_classify(input logic a, input logic b);
    case ({a, b})
      2'b00:   return KPG_KILL;
      2'b11:   return KPG_GEN;
      default: return KPG_PROP;
    endcase
  endfunction

  // hi covers more significant bits; propagate passes lo through
  function automatic kpg_e kpg_merge(input kpg_e hi, input kpg_e lo);
    return (hi == KPG_PROP) ? lo : hi;
  endfunction

endpackage

// File: rtl/cadd_classify.sv
module cadd_classify
  import cadd_pkg::*;
#(
  parameter int W = 24
) (
  input  logic [W-1:0]       a_i,
  input  logic [W-1:0]       b_i,
  output kpg_e [W-1:0]       st_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign st_o[i] = kpg_classify(a_i[i], b_i[i]);
  end

endmodule

// File: rtl/cadd_prefix.sv
module cadd_prefix
  import cadd_pkg::*;
#(
  parameter int W = 24
) (
  input  kpg_e [W-1:0] st_i,
  output kpg_e [W-1:0] grp_o
);

  localparam int LVL = (W > 1) ? $clog2(W) : 0;

  kpg_e [W-1:0] lvl [LVL+1];

  assign lvl[0] = st_i;

  // Kogge-Stone: level s merges spans 2**s apart
  for (genvar s = 0; s < LVL; s++) begin : g_lvl
    localparam int DIST = 1 << s;
    for (genvar i = 0; i < W; i++) begin : g_pos
      if (i >= DIST) begin : g_mrg
        assign lvl[s+1][i] = kpg_merge(lvl[s][i], lvl[s][i-DIST]);
      end else begin : g_pass
        assign lvl[s+1][i] = lvl[s][i];
      end
    end
  end

  assign grp_o = lvl[LVL];

endmodule

// File: rtl/cadd_carry.sv
module cadd_carry
  import cadd_pkg::*;
#(
  parameter int W = 24
) (
  input  kpg_e [W-1:0] grp_i,
  output logic [W:0]   c_plain_o,
  output logic [W:0]   c_inc_o
);

  assign c_plain_o[0] = 1'b0;
  assign c_inc_o[0]   = 1'b1;

  // seed sweep: kill seed for a+b, generate seed for a+b+1
  for (genvar i = 0; i < W; i++) begin : g_seed
    assign c_plain_o[i+1] = (kpg_merge(grp_i[i], KPG_KILL) == KPG_GEN);
    assign c_inc_o[i+1]   = (kpg_merge(grp_i[i], KPG_GEN) == KPG_GEN);
  end

endmodule

// File: rtl/cadd_sum.sv
module cadd_sum #(
  parameter int W = 24
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W:0]   c_plain_i,
  input  logic [W:0]   c_inc_i,
  input  logic         rnd_up_i,
  output logic [W-1:0] sum_o,
  output logic         sum_co_o,
  output logic [W-1:0] inc_o,
  output logic         inc_co_o,
  output logic [W-1:0] res_o,
  output logic         res_co_o
);

  logic [W-1:0] half;

  assign half     = a_i ^ b_i;
  assign sum_o    = half ^ c_plain_i[W-1:0];
  assign inc_o    = half ^ c_inc_i[W-1:0];
  assign sum_co_o = c_plain_i[W];
  assign inc_co_o = c_inc_i[W];

  // rounding becomes a select
  assign res_o    = rnd_up_i ? inc_o    : sum_o;
  assign res_co_o = rnd_up_i ? inc_co_o : sum_co_o;

endmodule

// File: rtl/compound_adder.sv
module compound_adder
  import cadd_pkg::*;
#(
  parameter int WIDTH = 24
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             rnd_up_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             sum_co_o,
  output logic [WIDTH-1:0] inc_o,
  output logic             inc_co_o,
  output logic [WIDTH-1:0] res_o,
  output logic             res_co_o
);

  kpg_e [WIDTH-1:0] bit_st;
  kpg_e [WIDTH-1:0] grp_st;
  logic [WIDTH:0]   c_plain;
  logic [WIDTH:0]   c_inc;

  cadd_classify #(.W(WIDTH)) i_classify (
    .a_i  (a_i),
    .b_i  (b_i),
    .st_o (bit_st)
  );

  cadd_prefix #(.W(WIDTH)) i_prefix (
    .st_i  (bit_st),
    .grp_o (grp_st)
  );

  cadd_carry #(.W(WIDTH)) i_carry (
    .grp_i     (grp_st),
    .c_plain_o (c_plain),
    .c_inc_o   (c_inc)
  );

  cadd_sum #(.W(WIDTH)) i_sum (
    .a_i       (a_i),
    .b_i       (b_i),
    .c_plain_i (c_plain),
    .c_inc_i   (c_inc),
    .rnd_up_i  (rnd_up_i),
    .sum_o     (sum_o),
    .sum_co_o  (sum_co_o),
    .inc_o     (inc_o),
    .inc_co_o  (inc_co_o),
    .res_o     (res_o),
    .res_co_o  (res_co_o)
  );

endmodule

// File: rtl/compound_adder_chk.sv
module compound_adder_chk #(
  parameter int W = 24
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         rnd_up_i,
  input logic [W-1:0] sum_o,
  input logic         sum_co_o,
  input logic [W-1:0] inc_o,
  input logic         inc_co_o,
  input logic [W-1:0] res_o,
  input logic         res_co_o
);

  logic [W:0] ref_sum;
  logic [W:0] got_sum;
  logic [W:0] got_inc;
  logic [W:0] got_res;

  assign ref_sum = {1'b0, a_i} + {1'b0, b_i};
  assign got_sum = {sum_co_o, sum_o};
  assign got_inc = {inc_co_o, inc_o};
  assign got_res = {res_co_o, res_o};

  always_comb begin
    a_r1_sum_exact: assert (got_sum == ref_sum)
      else $error("R1 sum %h vs %h", got_sum, ref_sum);
    a_r2_inc_succ: assert (got_inc == got_sum + 1'b1)
      else $error("R2 inc %h sum %h", got_inc, got_sum);
    if (!rnd_up_i) begin
      a_r3_sel_plain: assert (got_res == got_sum)
        else $error("R3 res %h", got_res);
    end else begin
      a_r4_sel_inc: assert (got_res == got_inc)
        else $error("R4 res %h", got_res);
    end
    if ((a_i ^ b_i) == {W{1'b1}}) begin
      a_r6_prop_chain: assert (inc_co_o && inc_o == '0)
        else $error("R6 inc %h", got_inc);
    end
  end

endmodule

bind compound_adder compound_adder_chk #(.W(WIDTH)) i_chk (
  .a_i      (a_i),
  .b_i      (b_i),
  .rnd_up_i (rnd_up_i),
  .sum_o    (sum_o),
  .sum_co_o (sum_co_o),
  .inc_o    (inc_o),
  .inc_co_o (inc_co_o),
  .res_o    (res_o),
  .res_co_o (res_co_o)
);

// File: tb/test_compound_adder.sv
`timescale 1ns/1ps
module test_compound_adder;

  localparam int W  = 24;
  localparam int WS = 6;
  localparam int NV = 12;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         rnd;
    logic [W:0]   res;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{24'h000000, 24'h000000, 1'b0, 25'h0000000},
    '{24'h000000, 24'h000000, 1'b1, 25'h0000001},
    '{24'hFFFFFF, 24'hFFFFFF, 1'b0, 25'h1FFFFFE},
    '{24'hFFFFFF, 24'hFFFFFF, 1'b1, 25'h1FFFFFF},
    '{24'hFFFFFF, 24'h000000, 1'b0, 25'h0FFFFFF},
    '{24'hFFFFFF, 24'h000000, 1'b1, 25'h1000000},
    '{24'h000004, 24'h00000E, 1'b0, 25'h0000012},
    '{24'h800000, 24'h800000, 1'b1, 25'h1000001},
    '{24'h123456, 24'h654321, 1'b0, 25'h0777777},
    '{24'h555555, 24'hAAAAAA, 1'b1, 25'h1000000},
    '{24'h7FFFFF, 24'h000001, 1'b0, 25'h0800000},
    '{24'hABCDEF, 24'hFEDCBA, 1'b1, 25'h1AAAAAA}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0]  a, b, sum, inc, res;
  logic          rnd, sum_co, inc_co, res_co;
  logic [WS-1:0] as, bs, sums, incs, ress;
  logic          rnds, sums_co, incs_co, ress_co;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  compound_adder #(.WIDTH(W)) i_compound_adder (
    .a_i(a), .b_i(b), .rnd_up_i(rnd),
    .sum_o(sum), .sum_co_o(sum_co), .inc_o(inc), .inc_co_o(inc_co),
    .res_o(res), .res_co_o(res_co)
  );

  compound_adder #(.WIDTH(WS)) i_compound_adder_small (
    .a_i(as), .b_i(bs), .rnd_up_i(rnds),
    .sum_o(sums), .sum_co_o(sums_co), .inc_o(incs), .inc_co_o(incs_co),
    .res_o(ress), .res_co_o(ress_co)
  );

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vr);
    @(posedge clk);
    a = va; b = vb; rnd = vr;
    @(negedge clk);
  endtask

  task automatic chk_wide(input string tag);
    logic [W:0] e_sum;
    e_sum = {1'b0, a} + {1'b0, b};
    chk({tag, " R1 sum"}, {sum_co, sum}, e_sum);
    chk({tag, " R2 inc"}, {inc_co, inc}, e_sum + 1'b1);
    if (rnd) chk({tag, " R4 res"}, {res_co, res}, e_sum + 1'b1);
    else     chk({tag, " R3 res"}, {res_co, res}, e_sum);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; rnd = 1'b0;
    as = '0; bs = '0; rnds = 1'b0;
    @(negedge clk);
    // idle state with zero operands, R7
    chk("R7 idle sum", {sum_co, sum}, 25'h0);
    chk("R7 idle inc", {inc_co, inc}, 25'h1);

    // vector table: R3 / R4 selection with stated results
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].a, VEC[i].b, VEC[i].rnd);
      chk(VEC[i].rnd ? "R4 table res" : "R3 table res", {res_co, res}, VEC[i].res);
      chk_wide("table");
    end

    // R5 all generate
    drive('1, '1, 1'b0);
    chk("R5 sum", {sum_co, sum}, {1'b1, {(W-1){1'b1}}, 1'b0});
    chk("R5 inc", {inc_co, inc}, {1'b1, {W{1'b1}}});

    // R6 all propagate
    drive(24'h0F0F0F, 24'hF0F0F0, 1'b1);
    chk("R6 sum", {sum_co, sum}, {1'b0, {W{1'b1}}});
    chk("R6 inc", {inc_co, inc}, {1'b1, {W{1'b0}}});
    chk("R6 res", {res_co, res}, {1'b1, {W{1'b0}}});

    // R7 all kill
    drive('0, '0, 1'b1);
    chk("R7 sum", {sum_co, sum}, 25'h0);
    chk("R7 inc", {inc_co, inc}, 25'h1);

    // R8 worked example on the narrow instance
    @(posedge clk);
    as = 6'b000100; bs = 6'b001110; rnds = 1'b0;
    @(negedge clk);
    chk("R8 sum", 25'({sums_co, sums}), 25'b0010010);
    chk("R8 inc", 25'({incs_co, incs}), 25'b0010011);
    chk("R8 res", 25'({ress_co, ress}), 25'b0010010);

    // R9 exhaustive narrow width
    for (int ia = 0; ia < (1 << WS); ia++) begin
      for (int ib = 0; ib < (1 << WS); ib++) begin
        logic [WS:0] e_s;
        @(posedge clk);
        as = WS'(ia); bs = WS'(ib); rnds = ((ia + ib) % 2) == 1;
        @(negedge clk);
        e_s = {1'b0, as} + {1'b0, bs};
        chk("R9 R1 narrow sum", 25'({sums_co, sums}), 25'(e_s));
        chk("R9 R2 narrow inc", 25'({incs_co, incs}), 25'(e_s + 1'b1));
        chk(rnds ? "R9 R4 narrow res" : "R9 R3 narrow res",
            25'({ress_co, ress}), rnds ? 25'(e_s + 1'b1) : 25'(e_s));
      end
    end

    // R9 random default width, all-ones mixed in
    for (int k = 0; k < 3000; k++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      if (k % 17 == 0) ra = '1;
      if (k % 23 == 0) rb = '1;
      if (k % 29 == 0) rb = ~ra;
      drive(ra, rb, k[0]);
      chk_wide("R9 random");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule